// File: doc/BRIEF.md
# Two-wire EEPROM page-write receiver

This block is the receive side of a small serial EEPROM on a two-wire bus. It runs on the chip clock and oversamples the bus clock and data lines. It finds START and STOP conditions and shifts in bytes most significant bit first. It acknowledges three kinds of byte in turn: a command byte that names the device, one word address byte, and then a run of data bytes.

Each data byte lands in an eight-entry page buffer at the position set by the three low bits of a running address. A valid bit is set for each entry that is written. The running address wraps inside the page, so the page bits never change during a burst.

A STOP closes the burst. It raises a one-cycle start pulse for the programming sequencer, which then reads the page base address, the buffer and the valid mask. While the sequencer reports busy, the command byte is not acknowledged. A master can therefore poll until the sequencer is free.

Top module: `eeprom_page_rx`

## Requirements
- R1: SDA falling while SCL is high (START) opens a transaction. SDA rising while SCL is high (STOP) closes it. Bits are taken on SCL rising edges, most significant first. Outside a transaction, no byte is acknowledged.
- R2: A command byte is acknowledged when its bits 7..1 equal `DEV_ID` and bit 0 (write) is 0. The acknowledge holds `sda_oe_o` high from the SCL falling edge after bit 0 until the next SCL falling edge. On any other command byte, that byte and every later byte go unacknowledged until the next START.
- R3: If `prog_busy_i` is high when the command byte completes, the command byte is not acknowledged, even if it matches.
- R4: The word address byte is always acknowledged. Its low `ADDR_W` bits set the start location. From that acknowledge on, `prog_base_o` shows the page of that location with its three low bits zero, and `prog_mask_o` is cleared.
- R5: Each data byte is acknowledged. It is stored in `prog_data_o[8k+7:8k]`, where k is the current offset (the location's three low bits), and `prog_mask_o[k]` is set.
- R6: The offset advances by one, modulo 8, only at the end of a data byte's acknowledge clock. The page bits stay fixed for the whole burst.
- R7: A ninth and later data byte overwrites the entry at the wrapped offset. The mask bits that are already set stay set.
- R8: A STOP in the data phase, with at least one entry stored, raises `prog_start_o` for exactly one clock cycle.
- R9: Some STOPs raise no start pulse: a STOP before any data byte, a STOP after an unacknowledged command byte, or a STOP that follows a repeated START. A repeated START abandons the burst in progress.
- R10: After reset, `sda_oe_o`, `prog_start_o`, `prog_mask_o`, `prog_data_o` and `prog_base_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Chip clock that oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe_o | output | 1 | High to pull the data line low (acknowledge) |
| prog_busy_i | input | 1 | Programming sequencer is busy |
| prog_start_o | output | 1 | One-cycle request to program the page |
| prog_base_o | output | ADDR_W | Page base address, low three bits zero |
| prog_data_o | output | 8*PAGE_BYTES | Page buffer, entry k in bits 8k+7..8k |
| prog_mask_o | output | PAGE_BYTES | One bit per entry written in the burst |

## Verification
The bench builds the block with `ADDR_W` = 8, `PAGE_BYTES` = 8 and `DEV_ID` = 7'h50. With an eight-bit address, the top bit of the word address falls inside the page field. A burst that starts at 0xFE can then wrap inside the highest page, which begins at 0xF8, without touching the page bits. A run of ten data bytes reaches the overwrite path. Device mismatch, a read request, busy polling, an address-only write and a repeated START each test a case in which no programming request may be raised.

// File: rtl/eprx_pkg.sv
package eprx_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_CMD  = 2'd1,
        PH_ADDR = 2'd2,
        PH_DATA = 2'd3
    } phase_e;

    localparam int BYTE_BITS = 8;

endpackage

// File: rtl/eprx_line_sync.sv
module eprx_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_o,
    output logic sda_o,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic start_o,
    output logic stop_o
);

    typedef struct packed {
        logic [STAGES-1:0] scl;
        logic [STAGES-1:0] sda;
        logic              scl_prev;
        logic              sda_prev;
    } sync_t;

    sync_t sync_d, sync_q;

    always_comb begin
        sync_d          = sync_q;
        sync_d.scl      = {sync_q.scl[STAGES-2:0], scl_i};
        sync_d.sda      = {sync_q.sda[STAGES-2:0], sda_i};
        sync_d.scl_prev = sync_q.scl[STAGES-1];
        sync_d.sda_prev = sync_q.sda[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '{scl: '1, sda: '1, scl_prev: 1'b1, sda_prev: 1'b1};
        end else begin
            sync_q <= sync_d;
        end
    end

    assign scl_o      = sync_q.scl[STAGES-1];
    assign sda_o      = sync_q.sda[STAGES-1];
    assign scl_rise_o = scl_o & ~sync_q.scl_prev;
    assign scl_fall_o = ~scl_o & sync_q.scl_prev;
    assign start_o    = scl_o & sync_q.scl_prev & sync_q.sda_prev & ~sda_o;
    assign stop_o     = scl_o & sync_q.scl_prev & ~sync_q.sda_prev & sda_o;

endmodule

// File: rtl/eprx_byte_shift.sv
module eprx_byte_shift #(
    parameter int BITS = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            restart_i,
    input  logic            rise_i,
    input  logic            fall_i,
    input  logic            sda_i,
    output logic [BITS-1:0] byte_o,
    output logic            byte_done_o,
    output logic            ack_end_o
);

    localparam int CNT_W = $clog2(BITS + 2);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(BITS);
    localparam logic [CNT_W-1:0] CNT_ACK  = CNT_W'(BITS + 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [BITS-1:0]  shreg;
    } shift_t;

    shift_t sh_d, sh_q;

    always_comb begin
        sh_d = sh_q;
        if (restart_i) begin
            sh_d.cnt = '0;
        end else begin
            if (rise_i) begin
                if (sh_q.cnt < CNT_FULL) begin
                    sh_d.shreg = {sh_q.shreg[BITS-2:0], sda_i};
                    sh_d.cnt   = sh_q.cnt + 1'b1;
                end else if (sh_q.cnt == CNT_FULL) begin
                    sh_d.cnt = CNT_ACK;
                end
            end
            if (fall_i && sh_q.cnt == CNT_ACK) begin
                sh_d.cnt = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q <= '{cnt: '0, shreg: '0};
        end else begin
            sh_q <= sh_d;
        end
    end

    assign byte_o      = sh_q.shreg;
    assign byte_done_o = fall_i && (sh_q.cnt == CNT_FULL);
    assign ack_end_o   = fall_i && (sh_q.cnt == CNT_ACK);

    assert_cnt_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
        sh_q.cnt <= CNT_ACK);

    assert_restart_clears_R1: assert property (@(posedge clk) disable iff (!rst_n)
        restart_i |=> (sh_q.cnt == '0));

endmodule

// File: rtl/eprx_page_buf.sv
module eprx_page_buf #(
    parameter int ENTRIES = 8,
    parameter int DW      = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       clr_i,
    input  logic                       wr_i,
    input  logic [$clog2(ENTRIES)-1:0] idx_i,
    input  logic [DW-1:0]              data_i,
    output logic [ENTRIES*DW-1:0]      data_o,
    output logic [ENTRIES-1:0]         mask_o
);

    localparam int IDX_W = $clog2(ENTRIES);

    for (genvar g = 0; g < ENTRIES; g++) begin : g_entry
        logic [DW-1:0] val_d, val_q;
        logic          vld_d, vld_q;

        always_comb begin
            val_d = val_q;
            vld_d = vld_q;
            if (clr_i) begin
                vld_d = 1'b0;
            end
            if (wr_i && idx_i == IDX_W'(g)) begin
                val_d = data_i;
                vld_d = 1'b1;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                val_q <= '0;
                vld_q <= 1'b0;
            end else begin
                val_q <= val_d;
                vld_q <= vld_d;
            end
        end

        assign data_o[g*DW +: DW] = val_q;
        assign mask_o[g]          = vld_q;
    end

    assert_write_marks_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_i |=> mask_o[$past(idx_i)]);

    assert_mask_keeps_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_i |=> ($countones(mask_o) >= $countones($past(mask_o))));

endmodule

// File: rtl/eeprom_page_rx.sv
module eeprom_page_rx
    import eprx_pkg::*;
#(
    parameter int         ADDR_W      = 7,
    parameter int         PAGE_BYTES  = 8,
    parameter int         SYNC_STAGES = 2,
    parameter logic [6:0] DEV_ID      = 7'h50
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    scl_i,
    input  logic                    sda_i,
    output logic                    sda_oe_o,
    input  logic                    prog_busy_i,
    output logic                    prog_start_o,
    output logic [ADDR_W-1:0]       prog_base_o,
    output logic [8*PAGE_BYTES-1:0] prog_data_o,
    output logic [PAGE_BYTES-1:0]   prog_mask_o
);

    localparam int OFS_W = $clog2(PAGE_BYTES);
    localparam int PG_W  = ADDR_W - OFS_W;

    typedef struct packed {
        phase_e           ph;
        logic             oe;
        logic             go;
        logic [PG_W-1:0]  pg;
        logic [OFS_W-1:0] ofs;
    } rx_state_t;

    rx_state_t st_d, st_q;

    logic scl_s, sda_s, scl_rise, scl_fall, bus_start, bus_stop;
    logic [BYTE_BITS-1:0] rx_byte;
    logic byte_done, ack_end;
    logic buf_wr, buf_clr;

    eprx_line_sync #(
        .STAGES (SYNC_STAGES)
    ) i_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl_i),
        .sda_i      (sda_i),
        .scl_o      (scl_s),
        .sda_o      (sda_s),
        .scl_rise_o (scl_rise),
        .scl_fall_o (scl_fall),
        .start_o    (bus_start),
        .stop_o     (bus_stop)
    );

    eprx_byte_shift #(
        .BITS (BYTE_BITS)
    ) i_shift (
        .clk         (clk),
        .rst_n       (rst_n),
        .restart_i   (bus_start | bus_stop),
        .rise_i      (scl_rise),
        .fall_i      (scl_fall),
        .sda_i       (sda_s),
        .byte_o      (rx_byte),
        .byte_done_o (byte_done),
        .ack_end_o   (ack_end)
    );

    eprx_page_buf #(
        .ENTRIES (PAGE_BYTES),
        .DW      (BYTE_BITS)
    ) i_buf (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (buf_clr),
        .wr_i   (buf_wr),
        .idx_i  (st_q.ofs),
        .data_i (rx_byte),
        .data_o (prog_data_o),
        .mask_o (prog_mask_o)
    );

    always_comb begin
        st_d    = st_q;
        st_d.go = 1'b0;
        buf_wr  = 1'b0;
        buf_clr = 1'b0;
        if (bus_start) begin
            st_d.ph = PH_CMD;
            st_d.oe = 1'b0;
        end else if (bus_stop) begin
            st_d.go = (st_q.ph == PH_DATA) && (|prog_mask_o);
            st_d.ph = PH_IDLE;
            st_d.oe = 1'b0;
        end else if (byte_done) begin
            unique case (st_q.ph)
                PH_CMD: begin
                    if (rx_byte[7:1] == DEV_ID && !rx_byte[0] && !prog_busy_i) begin
                        st_d.oe = 1'b1;
                    end else begin
                        st_d.ph = PH_IDLE;
                    end
                end
                PH_ADDR: begin
                    st_d.oe  = 1'b1;
                    st_d.pg  = rx_byte[ADDR_W-1:OFS_W];
                    st_d.ofs = rx_byte[OFS_W-1:0];
                    buf_clr  = 1'b1;
                end
                PH_DATA: begin
                    st_d.oe = 1'b1;
                    buf_wr  = 1'b1;
                end
                default: ;
            endcase
        end else if (ack_end) begin
            st_d.oe = 1'b0;
            unique case (st_q.ph)
                PH_CMD:  st_d.ph  = PH_ADDR;
                PH_ADDR: st_d.ph  = PH_DATA;
                PH_DATA: st_d.ofs = st_q.ofs + 1'b1;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{ph: PH_IDLE, oe: 1'b0, go: 1'b0, pg: '0, ofs: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign sda_oe_o     = st_q.oe;
    assign prog_start_o = st_q.go;
    assign prog_base_o  = {st_q.pg, {OFS_W{1'b0}}};

    assert_ack_while_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.oe) |-> !scl_s);

    assert_busy_refused_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ph == PH_CMD && byte_done && prog_busy_i) |=> !sda_oe_o);

    assert_page_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ph == PH_DATA && $past(st_q.ph) == PH_DATA) |-> $stable(st_q.pg));

    assert_go_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        prog_start_o |=> !prog_start_o);

    assert_go_needs_data_R9: assert property (@(posedge clk) disable iff (!rst_n)
        prog_start_o |-> (prog_mask_o != '0));

endmodule

// File: tb/test_eeprom_page_rx.sv
`timescale 1ns/1ps
module test_eeprom_page_rx;

    localparam int AW = 8;
    localparam int PB = 8;
    localparam logic [6:0] DEV = 7'h50;
    localparam int Q = 6;
    localparam int H = 12;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic busy  = 1'b0;
    logic sda_oe, prog_start;
    logic [AW-1:0]   prog_base;
    logic [8*PB-1:0] prog_data;
    logic [PB-1:0]   prog_mask;
    wire sda_bus = sda_m & ~sda_oe;

    eeprom_page_rx #(
        .ADDR_W (AW), .PAGE_BYTES (PB), .SYNC_STAGES (2), .DEV_ID (DEV)
    ) i_eeprom_page_rx (
        .clk (clk), .rst_n (rst_n), .scl_i (scl_m), .sda_i (sda_bus),
        .sda_oe_o (sda_oe), .prog_busy_i (busy), .prog_start_o (prog_start),
        .prog_base_o (prog_base), .prog_data_o (prog_data), .prog_mask_o (prog_mask)
    );

    int total = 0;
    int bad = 0;
    int pulses = 0;

    task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // behavioural reference, clocked with the design
    bit d1c = 1, d2c = 1, d3c = 1, d1a = 1, d2a = 1, d3a = 1;
    int ph = 0, nb = 0, of = 0, pg = 0;
    bit [7:0] sh = 0;
    bit m_oe = 0, m_go = 0;
    bit [7:0] mdat [PB];
    bit [PB-1:0] mmask = 0;

    always @(posedge clk) begin : ref_model
        bit smp, rise, fall, stt, stp;
        smp = sda_m & ~m_oe;
        if (!rst_n) begin
            d1c = 1; d2c = 1; d3c = 1; d1a = 1; d2a = 1; d3a = 1;
            ph = 0; nb = 0; of = 0; pg = 0; sh = 0; m_oe = 0; m_go = 0; mmask = 0;
            for (int k = 0; k < PB; k++) mdat[k] = 0;
        end else begin
            rise = d2c & !d3c;
            fall = !d2c & d3c;
            stt  = d2c & d3c & d3a & !d2a;
            stp  = d2c & d3c & !d3a & d2a;
            m_go = 0;
            if (stt) begin
                ph = 1; nb = 0; m_oe = 0;
            end else if (stp) begin
                m_go = (ph == 3) && (mmask != 0);
                ph = 0; nb = 0; m_oe = 0;
            end else begin
                if (rise) begin
                    if (nb < 8) begin sh = {sh[6:0], d2a}; nb++; end
                    else if (nb == 8) nb = 9;
                end
                if (fall && nb == 8) begin
                    if (ph == 1) begin
                        if (sh[7:1] == DEV && !sh[0] && !busy) m_oe = 1; else ph = 0;
                    end else if (ph == 2) begin
                        m_oe = 1; pg = int'(sh[AW-1:3]); of = int'(sh[2:0]); mmask = 0;
                    end else if (ph == 3) begin
                        m_oe = 1; mdat[of] = sh; mmask[of] = 1;
                    end
                end else if (fall && nb == 9) begin
                    nb = 0; m_oe = 0;
                    if (ph == 1) ph = 2;
                    else if (ph == 2) ph = 3;
                    else if (ph == 3) of = (of + 1) % 8;
                end
            end
            d3c = d2c; d2c = d1c; d1c = scl_m;
            d3a = d2a; d2a = d1a; d1a = smp;
        end
    end

    function automatic logic [8*PB-1:0] ref_data();
        logic [8*PB-1:0] v;
        for (int k = 0; k < PB; k++) v[k*8 +: 8] = mdat[k];
        return v;
    endfunction

    always @(negedge clk) begin
        if (rst_n) begin
            if (prog_start) pulses++;
            chk("R2", "ack drive vs model", 64'(sda_oe), 64'(m_oe));
            chk("R8", "start pulse vs model", 64'(prog_start), 64'(m_go));
            chk("R5", "mask vs model", 64'(prog_mask), 64'(mmask));
            chk("R4", "base vs model", 64'(prog_base), 64'(pg * 8));
            chk("R5", "data vs model", 64'(prog_data), 64'(ref_data()));
        end
    end

    task automatic wclk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1; wclk(Q); scl_m = 1; wclk(H); sda_m = 0; wclk(H); scl_m = 0; wclk(Q);
    endtask

    task automatic bus_stop();
        sda_m = 0; wclk(Q); scl_m = 1; wclk(H); sda_m = 1; wclk(H);
    endtask

    task automatic send(input logic [7:0] b, output bit ack);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; wclk(Q); scl_m = 1; wclk(H); scl_m = 0; wclk(Q);
        end
        sda_m = 1; wclk(Q); scl_m = 1; wclk(Q);
        ack = !sda_bus;
        wclk(Q); scl_m = 0; wclk(Q);
    endtask

    logic [7:0] tx_q [$];

    task automatic xfer(input bit do_stop, output logic [15:0] acks);
        bit a;
        acks = '0;
        bus_start();
        foreach (tx_q[i]) begin
            send(tx_q[i], a);
            acks[i] = a;
        end
        if (do_stop) bus_stop();
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        logic [15:0] acks;
        int p0;
        wclk(5);
        rst_n = 1;
        wclk(2);
        chk("R10", "reset ack", 64'(sda_oe), 0);
        chk("R10", "reset start", 64'(prog_start), 0);
        chk("R10", "reset mask", 64'(prog_mask), 0);
        chk("R10", "reset data", 64'(prog_data), 0);
        chk("R10", "reset base", 64'(prog_base), 0);

        // basic burst, MSB-first bytes
        p0 = pulses;
        tx_q = '{8'hA0, 8'h13, 8'h11, 8'h22, 8'h33};
        xfer(1, acks);
        chk("R2", "acks basic", 64'(acks), 64'h1F);
        chk("R8", "one pulse basic", 64'(pulses - p0), 1);
        chk("R4", "base basic", 64'(prog_base), 64'h10);
        chk("R5", "mask basic", 64'(prog_mask), 64'h38);
        chk("R1", "msb-first data basic", 64'(prog_data), 64'h0000_3322_1100_0000);

        // wrap inside the top page
        p0 = pulses;
        tx_q = '{8'hA0, 8'hFE, 8'h01, 8'h02, 8'h03, 8'h04};
        xfer(1, acks);
        chk("R6", "base wrap", 64'(prog_base), 64'hF8);
        chk("R6", "mask wrap", 64'(prog_mask), 64'hC3);
        chk("R6", "data wrap", 64'(prog_data), 64'h0201_3322_1100_0403);
        chk("R8", "one pulse wrap", 64'(pulses - p0), 1);

        // more than a page of data
        p0 = pulses;
        tx_q = '{8'hA0, 8'h20, 8'hB0, 8'hB1, 8'hB2, 8'hB3, 8'hB4, 8'hB5,
                 8'hB6, 8'hB7, 8'hB8, 8'hB9};
        xfer(1, acks);
        chk("R5", "acks long", 64'(acks), 64'hFFF);
        chk("R7", "mask long", 64'(prog_mask), 64'hFF);
        chk("R7", "data long", 64'(prog_data), 64'hB7B6_B5B4_B3B2_B9B8);
        chk("R8", "one pulse long", 64'(pulses - p0), 1);

        // wrong device code
        p0 = pulses;
        tx_q = '{8'hA2, 8'h00, 8'h55};
        xfer(1, acks);
        chk("R2", "acks wrong device", 64'(acks), 0);
        chk("R9", "no pulse wrong device", 64'(pulses - p0), 0);
        chk("R9", "data kept wrong device", 64'(prog_data), 64'hB7B6_B5B4_B3B2_B9B8);

        // read request
        p0 = pulses;
        tx_q = '{8'hA1};
        xfer(1, acks);
        chk("R2", "ack read request", 64'(acks), 0);

        // busy polling
        busy = 1;
        p0 = pulses;
        tx_q = '{8'hA0, 8'h00, 8'h66};
        xfer(1, acks);
        chk("R3", "acks while busy", 64'(acks), 0);
        chk("R3", "no pulse while busy", 64'(pulses - p0), 0);
        busy = 0;

        // address only
        p0 = pulses;
        tx_q = '{8'hA0, 8'h4D};
        xfer(1, acks);
        chk("R4", "acks address only", 64'(acks), 64'h3);
        chk("R4", "mask cleared", 64'(prog_mask), 0);
        chk("R4", "base address only", 64'(prog_base), 64'h48);
        chk("R9", "no pulse address only", 64'(pulses - p0), 0);

        // repeated START abandons the burst
        p0 = pulses;
        tx_q = '{8'hA0, 8'h40, 8'h55};
        xfer(0, acks);
        chk("R5", "acks before restart", 64'(acks), 64'h7);
        tx_q = '{8'hA0};
        xfer(1, acks);
        chk("R1", "ack after restart", 64'(acks), 64'h1);
        chk("R9", "no pulse after restart", 64'(pulses - p0), 0);
        chk("R5", "mask after restart", 64'(prog_mask), 64'h01);

        wclk(10);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule